// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block arbitrates interrupts for a small 8-bit processor core. Five sources can raise a request: an external pin edge, two timer overflows, a time-base tick and one grouped source. The grouped source collects a comparator event and two amplifier falling-edge events, and each of those three keeps its own sub-flag. Every request is held in a flag until it is acknowledged or software clears it. Each source has its own enable, and one master enable covers all of them.

The core supplies a strobe once per instruction cycle. On a strobe, the block picks the highest-priority flag that is both pending and enabled, provided three things hold: the master enable is set, the return stack is not full, and no earlier entry is still in progress. Picking a source acknowledges it. The master enable clears, the chosen top-level flag clears, and a fixed entry delay starts, counted in strobes. When the delay ends, the block gives the core a one-clock request to push the program counter and jump, together with the vector address of the chosen source. A wake output tells the sleep logic that some enabled request is waiting, whatever the state of the master enable.

Top module: `irq_arb_top`

## Requirements
- R1: An event on `ext_edge`, `tmr0_ovf`, `tmr1_ovf` or `tbase_tick` sets `flags` bit 0, 1, 2 or 3 on the next clock. An event is never lost: it wins over a hardware or software clear in the same cycle.
- R2: A pulse on `cmp_evt`, `amp0_fall` or `amp1_fall` sets `mf_sub` bit 0, 1 or 2 and also `flags` bit 4 on the next clock. Sub-flags are cleared only by a software write.
- R3: When several flags are pending and enabled, the lowest bit index wins: bit 0 has the highest priority and bit 4 the lowest.
- R4: The vector for flag bits 0 to 4 is 0x04, 0x08, 0x0C, 0x14 and 0x18. It is valid while `irq_take` is high.
- R5: Acknowledge happens only in a cycle with `phase_stb` high. A flag whose enable bit is clear is never selected.
- R6: On acknowledge, `master_en` and the winning `flags` bit read 0 on the next clock. Other flags and the sub-flags are untouched.
- R7: A request raised while `master_en` is 0 stays pending and is taken on a strobe after `master_en` is set again.
- R8: `irq_take` is a one-clock pulse. It is high in the clock after the 2nd strobe that follows the acknowledging strobe, or after the 3rd if `sleeping` was high at acknowledge. No other acknowledge happens meanwhile.
- R9: A pulse on `reti` sets `master_en`, unless an acknowledge happens in the same cycle. A write with `sw_we` stores `sw_val` into the item chosen by `sw_sel`: 0 is the master enable, 1 to 5 are enable bits 0 to 4, 6 to 10 are flag bits 0 to 4, and 11 to 13 are sub-flag bits 0 to 2. Codes 14 and 15 change nothing.
- R10: `wake` is high exactly when some flag bit and its enable bit are both 1, whatever `master_en` holds.
- R11: No acknowledge happens on a strobe while `stack_full` is high. Pending flags stay set and are taken on a later strobe once `stack_full` is low.
- R12: After reset, all flags, enables, sub-flags, `master_en`, `irq_take` and `wake` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_edge | input | 1 | External pin active-edge event |
| tmr0_ovf | input | 1 | Timer 0 overflow event |
| tmr1_ovf | input | 1 | Timer 1 overflow event |
| tbase_tick | input | 1 | Time-base event |
| cmp_evt | input | 1 | Comparator output transition event |
| amp0_fall | input | 1 | Amplifier 0 output falling edge |
| amp1_fall | input | 1 | Amplifier 1 output falling edge |
| phase_stb | input | 1 | Once-per-instruction-cycle sampling strobe |
| stack_full | input | 1 | Return stack has no free entry |
| sleeping | input | 1 | Core is in sleep or idle |
| reti | input | 1 | Return-from-interrupt executed |
| sw_we | input | 1 | Software write strobe |
| sw_sel | input | 4 | Software write item select |
| sw_val | input | 1 | Software write value |
| irq_take | output | 1 | One-clock push-and-jump request |
| irq_vector | output | 8 | Vector address of the taken source |
| master_en | output | 1 | Master enable |
| flags | output | 5 | Top-level request flags |
| enables | output | 5 | Per-source enables |
| mf_sub | output | 3 | Grouped-source sub-flags |
| wake | output | 1 | Some enabled request is pending |

## Verification
Flag, enable, sub-flag and master-enable results appear one clock after the input edge that causes them. `wake` follows the flag and enable registers in the same clock. `irq_take` is counted in strobes, not clocks: it comes one clock after the 2nd or 3rd strobe following acknowledge, so irregular strobe spacing tests that the count follows `phase_stb`. The bench drives inputs on the falling edge and updates its own model on the rising edge, then compares every output 1 ns later. Each result is therefore checked in the exact clock it becomes due, with no allowance window.

// File: rtl/irq_arb_pkg.sv
// Package: shared sizes, software-select codes and the vector map of the
// interrupt arbiter. Assumes five top-level sources, the last one grouped.
package irq_arb_pkg;
    localparam int NUM_SRC  = 5;
    localparam int NUM_SUB  = 3;
    localparam int VEC_W    = 8;
    localparam int SEL_W    = 4;

    // software select codes
    localparam int SEL_MASTER    = 0;
    localparam int SEL_EN_BASE   = 1;
    localparam int SEL_FLAG_BASE = SEL_EN_BASE + NUM_SRC;
    localparam int SEL_SUB_BASE  = SEL_FLAG_BASE + NUM_SRC;

    // vector address of each source; the map has a gap after index 2
    function automatic logic [VEC_W-1:0] vec_of(input int idx);
        logic [VEC_W-1:0] v;
        v = VEC_W'((idx + 1) * 4);
        if (idx >= 3) v = VEC_W'((idx + 2) * 4);
        return v;
    endfunction
endpackage

// File: rtl/irq_flag_bank.sv
// Flag bank: holds the request flags, per-source enables and grouped
// sub-flags. Assumes event pulses are one clock wide, and that an event
// overrides any clear applied in the same clock.
module irq_flag_bank
    import irq_arb_pkg::*;
#(
    parameter int N_SRC = NUM_SRC,
    parameter int N_SUB = NUM_SUB,
    parameter int SW    = SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-2:0] evt_main,
    input  logic [N_SUB-1:0] evt_sub,
    input  logic [N_SRC-1:0] ack_clr,
    input  logic             sw_we,
    input  logic [SW-1:0]    sw_sel,
    input  logic             sw_val,
    output logic [N_SRC-1:0] flags,
    output logic [N_SRC-1:0] enables,
    output logic [N_SUB-1:0] sub_flags
);
    logic [N_SRC-1:0] evt_all;

    // grouped source raises its top flag when any member fires
    always_comb begin
        evt_all = {(|evt_sub), evt_main};
    end

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        localparam logic [SW-1:0] EN_CODE = SW'(SEL_EN_BASE + i);
        localparam logic [SW-1:0] FL_CODE = SW'(SEL_FLAG_BASE + i);

        // per-source enable bit, written by software only
        always_ff @(posedge clk) begin
            if (!rst_n)                               enables[i] <= 1'b0;
            else if (sw_we && sw_sel == EN_CODE)      enables[i] <= sw_val;
        end

        // request flag: ack clear, then software write, then event set
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags[i] <= 1'b0;
            end else if (evt_all[i]) begin
                flags[i] <= 1'b1;
            end else if (sw_we && sw_sel == FL_CODE) begin
                flags[i] <= sw_val;
            end else if (ack_clr[i]) begin
                flags[i] <= 1'b0;
            end
        end
    end

    for (genvar j = 0; j < N_SUB; j++) begin : g_sub
        localparam logic [SW-1:0] SB_CODE = SW'(SEL_SUB_BASE + j);

        // grouped sub-flag: set by its event, cleared only by software
        always_ff @(posedge clk) begin
            if (!rst_n)                               sub_flags[j] <= 1'b0;
            else if (evt_sub[j])                      sub_flags[j] <= 1'b1;
            else if (sw_we && sw_sel == SB_CODE)      sub_flags[j] <= sw_val;
        end
    end
endmodule

// File: rtl/irq_prio_sel.sv
// Priority selector: one-hot grant of the lowest-index pending and enabled
// source, plus that source's vector. Purely combinational.
module irq_prio_sel
    import irq_arb_pkg::*;
#(
    parameter int N_SRC = NUM_SRC,
    parameter int VW    = VEC_W
) (
    input  logic [N_SRC-1:0] flags,
    input  logic [N_SRC-1:0] enables,
    output logic [N_SRC-1:0] grant,
    output logic             any_pend,
    output logic [VW-1:0]    win_vec
);
    logic [N_SRC-1:0] pend;

    // a request counts only when its enable is set
    always_comb begin
        pend     = flags & enables;
        any_pend = |pend;
    end

    for (genvar i = 0; i < N_SRC; i++) begin : g_grant
        if (i == 0) begin : g_top
            // the highest-priority source needs no mask
            always_comb grant[i] = pend[i];
        end else begin : g_rest
            // lower sources lose to any pending higher one
            always_comb grant[i] = pend[i] & ~(|pend[i-1:0]);
        end
    end

    // OR together the vectors of the (at most one) granted source
    always_comb begin
        win_vec = '0;
        for (int k = 0; k < N_SRC; k++) begin
            if (grant[k]) win_vec = win_vec | VW'(vec_of(k));
        end
    end
endmodule

// File: rtl/irq_entry_seq.sv
// Entry sequencer: owns the master enable, decides acknowledge on a
// strobe, and counts the entry latency in strobes before raising the
// one-clock take pulse. Assumes stack_full and sleeping are stable
// around the strobe.
module irq_entry_seq
    import irq_arb_pkg::*;
#(
    parameter int VW       = VEC_W,
    parameter int SW       = SEL_W,
    parameter int LAT_RUN  = 2,
    parameter int LAT_WAKE = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          phase_stb,
    input  logic          stack_full,
    input  logic          sleeping,
    input  logic          reti,
    input  logic          sw_we,
    input  logic [SW-1:0] sw_sel,
    input  logic          sw_val,
    input  logic          any_pend,
    input  logic [VW-1:0] win_vec,
    output logic          ack,
    output logic          master_en,
    output logic          busy,
    output logic          irq_take,
    output logic [VW-1:0] irq_vector
);
    localparam int CNT_W = $clog2(LAT_WAKE + 1);
    localparam logic [SW-1:0] ME_CODE = SW'(SEL_MASTER);

    logic [CNT_W-1:0] lat_cnt;

    // acknowledge only on a strobe with nothing blocking
    always_comb begin
        ack = phase_stb && master_en && !stack_full && !busy && any_pend;
    end

    // master enable: ack clears, return sets, software writes last
    always_ff @(posedge clk) begin
        if (!rst_n)                              master_en <= 1'b0;
        else if (ack)                            master_en <= 1'b0;
        else if (reti)                           master_en <= 1'b1;
        else if (sw_we && sw_sel == ME_CODE)     master_en <= sw_val;
    end

    // latency counter and take pulse, counted in strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            lat_cnt  <= '0;
            irq_take <= 1'b0;
        end else begin
            irq_take <= 1'b0;
            if (ack) begin
                busy    <= 1'b1;
                lat_cnt <= sleeping ? CNT_W'(LAT_WAKE) : CNT_W'(LAT_RUN);
            end else if (busy && phase_stb) begin
                if (lat_cnt == CNT_W'(1)) begin
                    busy     <= 1'b0;
                    irq_take <= 1'b1;
                end
                lat_cnt <= lat_cnt - CNT_W'(1);
            end
        end
    end

    // vector captured at acknowledge and held for the take pulse
    always_ff @(posedge clk) begin
        if (!rst_n)   irq_vector <= '0;
        else if (ack) irq_vector <= win_vec;
    end
endmodule

// File: rtl/irq_arb_top.sv
// Top of the interrupt arbiter: wires the flag bank, priority selector
// and entry sequencer together. Assumes all inputs are synchronous to clk.
module irq_arb_top
    import irq_arb_pkg::*;
#(
    parameter int LAT_RUN  = 2,
    parameter int LAT_WAKE = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ext_edge,
    input  logic               tmr0_ovf,
    input  logic               tmr1_ovf,
    input  logic               tbase_tick,
    input  logic               cmp_evt,
    input  logic               amp0_fall,
    input  logic               amp1_fall,
    input  logic               phase_stb,
    input  logic               stack_full,
    input  logic               sleeping,
    input  logic               reti,
    input  logic               sw_we,
    input  logic [SEL_W-1:0]   sw_sel,
    input  logic               sw_val,
    output logic               irq_take,
    output logic [VEC_W-1:0]   irq_vector,
    output logic               master_en,
    output logic [NUM_SRC-1:0] flags,
    output logic [NUM_SRC-1:0] enables,
    output logic [NUM_SUB-1:0] mf_sub,
    output logic               wake
);
    logic [NUM_SRC-2:0] evt_main;
    logic [NUM_SUB-1:0] evt_sub;
    logic [NUM_SRC-1:0] grant;
    logic [NUM_SRC-1:0] ack_clr;
    logic               any_pend;
    logic [VEC_W-1:0]   win_vec;
    logic               ack;
    logic               entry_busy;

    // gather event pulses into vectors in priority order
    always_comb begin
        evt_main = {tbase_tick, tmr1_ovf, tmr0_ovf, ext_edge};
        evt_sub  = {amp1_fall, amp0_fall, cmp_evt};
    end

    // the winning flag is cleared only when it is acknowledged
    always_comb begin
        ack_clr = ack ? grant : '0;
        wake    = any_pend;
    end

    irq_flag_bank #(
        .N_SRC (NUM_SRC),
        .N_SUB (NUM_SUB),
        .SW    (SEL_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_main  (evt_main),
        .evt_sub   (evt_sub),
        .ack_clr   (ack_clr),
        .sw_we     (sw_we),
        .sw_sel    (sw_sel),
        .sw_val    (sw_val),
        .flags     (flags),
        .enables   (enables),
        .sub_flags (mf_sub)
    );

    irq_prio_sel #(
        .N_SRC (NUM_SRC),
        .VW    (VEC_W)
    ) u_prio (
        .flags    (flags),
        .enables  (enables),
        .grant    (grant),
        .any_pend (any_pend),
        .win_vec  (win_vec)
    );

    irq_entry_seq #(
        .VW       (VEC_W),
        .SW       (SEL_W),
        .LAT_RUN  (LAT_RUN),
        .LAT_WAKE (LAT_WAKE)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_stb  (phase_stb),
        .stack_full (stack_full),
        .sleeping   (sleeping),
        .reti       (reti),
        .sw_we      (sw_we),
        .sw_sel     (sw_sel),
        .sw_val     (sw_val),
        .any_pend   (any_pend),
        .win_vec    (win_vec),
        .ack        (ack),
        .master_en  (master_en),
        .busy       (entry_busy),
        .irq_take   (irq_take),
        .irq_vector (irq_vector)
    );
endmodule

// File: rtl/irq_arb_chk.sv
// Checker: temporal properties of the arbiter, attached by bind.
module irq_arb_chk
    import irq_arb_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               ext_edge,
    input logic               phase_stb,
    input logic               stack_full,
    input logic               sw_we,
    input logic               irq_take,
    input logic [VEC_W-1:0]   irq_vector,
    input logic               master_en,
    input logic [NUM_SRC-1:0] flags,
    input logic [NUM_SUB-1:0] mf_sub,
    input logic               wake,
    input logic               entry_busy
);
    // R1: an external edge always shows up in its flag
    a_r1_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ext_edge |=> flags[0]);

    // R2: without a software write, no sub-flag falls
    a_r2_sub_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_we |=> ((mf_sub & $past(mf_sub)) == $past(mf_sub)));

    // R4: a taken vector is one of the five legal addresses
    a_r4_vec_legal: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> (irq_vector == 8'h04 || irq_vector == 8'h08 ||
                      irq_vector == 8'h0C || irq_vector == 8'h14 ||
                      irq_vector == 8'h18));

    // R5 and R11: an entry only starts on an unblocked strobe
    a_r11_no_ack_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(entry_busy) |-> $past(phase_stb && master_en && !stack_full));

    // R6: entry start leaves the master enable cleared
    a_r6_me_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(entry_busy) |-> !master_en);

    // R8: take follows a strobe during an entry and lasts one clock
    a_r8_take_on_stb: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> ($past(phase_stb) && $past(entry_busy) && !entry_busy));

    a_r8_take_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |=> !irq_take);

    // R10: an entry never starts without a wake-worthy request
    a_r10_wake_before: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(entry_busy) |-> $past(wake));
endmodule

bind irq_arb_top irq_arb_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_edge   (ext_edge),
    .phase_stb  (phase_stb),
    .stack_full (stack_full),
    .sw_we      (sw_we),
    .irq_take   (irq_take),
    .irq_vector (irq_vector),
    .master_en  (master_en),
    .flags      (flags),
    .mf_sub     (mf_sub),
    .wake       (wake),
    .entry_busy (entry_busy)
);

// File: tb/irq_arb_top_tb_top.sv
// Bench: seeded random plus directed stimulus, checked against a model
// built from the requirements.
module irq_arb_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_edge = 0, tmr0_ovf = 0, tmr1_ovf = 0, tbase_tick = 0;
    logic       cmp_evt = 0, amp0_fall = 0, amp1_fall = 0;
    logic       phase_stb = 0, stack_full = 0, sleeping = 0, reti = 0;
    logic       sw_we = 0, sw_val = 0;
    logic [3:0] sw_sel = '0;
    logic       irq_take, master_en, wake;
    logic [7:0] irq_vector;
    logic [4:0] flags, enables;
    logic [2:0] mf_sub;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // model state
    logic [4:0] m_fl = '0, m_en = '0;
    logic [2:0] m_sub = '0;
    logic       m_me = 0, m_busy = 0, m_take = 0;
    int         m_cnt = 0;
    logic [7:0] m_vec = '0;

    always #2 clk = ~clk;

    irq_arb_top dut_i (
        .clk(clk), .rst_n(rst_n), .ext_edge(ext_edge), .tmr0_ovf(tmr0_ovf),
        .tmr1_ovf(tmr1_ovf), .tbase_tick(tbase_tick), .cmp_evt(cmp_evt),
        .amp0_fall(amp0_fall), .amp1_fall(amp1_fall), .phase_stb(phase_stb),
        .stack_full(stack_full), .sleeping(sleeping), .reti(reti),
        .sw_we(sw_we), .sw_sel(sw_sel), .sw_val(sw_val), .irq_take(irq_take),
        .irq_vector(irq_vector), .master_en(master_en), .flags(flags),
        .enables(enables), .mf_sub(mf_sub), .wake(wake)
    );

    function automatic logic [7:0] exp_vec(input int idx);
        case (idx)
            0: return 8'h04;
            1: return 8'h08;
            2: return 8'h0C;
            3: return 8'h14;
            default: return 8'h18;
        endcase
    endfunction

    function automatic int exp_win(input logic [4:0] p);
        for (int i = 0; i < 5; i++) if (p[i]) return i;
        return -1;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk("R1/R6 flags", flags, m_fl);
        chk("R9 enables", enables, m_en);
        chk("R2 mf_sub", mf_sub, m_sub);
        chk("R9/R6 master_en", master_en, m_me);
        chk("R10 wake", wake, |(m_fl & m_en));
        chk("R8 irq_take", irq_take, m_take);
        if (m_take) chk("R4/R3 irq_vector", irq_vector, m_vec);
    endtask

    // one clock: set inputs at the falling edge, advance model, compare
    task automatic step(input logic [6:0] ev, input logic stb, input logic sf,
                        input logic slp, input logic rt, input logic we,
                        input logic [3:0] sel, input logic val);
        logic [4:0] pend, n_fl, n_en, evt;
        logic [2:0] n_sub;
        logic       cap, n_me, n_take, n_busy;
        int         w, n_cnt;
        logic [7:0] n_vec;
        @(negedge clk);
        {amp1_fall, amp0_fall, cmp_evt, tbase_tick, tmr1_ovf, tmr0_ovf, ext_edge} = ev;
        phase_stb = stb; stack_full = sf; sleeping = slp; reti = rt;
        sw_we = we; sw_sel = sel; sw_val = val;
        pend = m_fl & m_en;
        cap  = stb && m_me && !sf && !m_busy && (pend != 0);
        w    = exp_win(pend);
        evt  = {|ev[6:4], ev[3:0]};
        n_fl = m_fl; n_en = m_en; n_sub = m_sub;
        if (cap) n_fl[w] = 1'b0;
        if (we && sel >= 1 && sel <= 5)  n_en[sel-1] = val;
        if (we && sel >= 6 && sel <= 10) n_fl[sel-6] = val;
        if (we && sel >= 11 && sel <= 13) n_sub[sel-11] = val;
        n_fl  = n_fl | evt;
        n_sub = n_sub | ev[6:4];
        n_me  = cap ? 1'b0 : rt ? 1'b1 : (we && sel == 0) ? val : m_me;
        n_take = 0; n_busy = m_busy; n_cnt = m_cnt; n_vec = m_vec;
        if (cap) begin
            n_busy = 1; n_cnt = slp ? 3 : 2; n_vec = exp_vec(w);
        end else if (m_busy && stb) begin
            if (m_cnt == 1) begin n_busy = 0; n_take = 1; end
            n_cnt = m_cnt - 1;
        end
        @(posedge clk);
        m_fl = n_fl; m_en = n_en; m_sub = n_sub; m_me = n_me;
        m_take = n_take; m_busy = n_busy; m_cnt = n_cnt; m_vec = n_vec;
        #1 compare();
    endtask

    task automatic idle(input int n, input logic stb);
        for (int i = 0; i < n; i++) step(7'h0, stb, 0, 0, 0, 0, 4'd0, 0);
    endtask

    task automatic sw(input logic [3:0] sel, input logic val);
        step(7'h0, 0, 0, 0, 0, 1, sel, val);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R12: reset state
        chk("R12 flags", flags, 0);
        chk("R12 master_en", master_en, 0);
        chk("R12 irq_take", irq_take, 0);
        chk("R12 wake", wake, 0);
        chk("R12 mf_sub", mf_sub, 0);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1 compare();

        // R7: request while master disabled stays pending
        step(7'h02, 1, 0, 0, 0, 0, 4'd0, 0);
        for (int i = 1; i <= 5; i++) sw(4'(i), 1);
        idle(3, 1);
        sw(4'd0, 1);
        idle(6, 1);

        // R3: all sources at once, ordered service, R8 run latency
        step(7'h7F, 0, 0, 0, 0, 0, 4'd0, 0);
        for (int k = 0; k < 5; k++) begin
            step(7'h0, 0, 0, 0, 1, 0, 4'd0, 0);
            idle(7, 1);
        end
        // R8: wake latency with spaced strobes
        step(7'h08, 0, 0, 0, 1, 0, 4'd0, 0);
        step(7'h0, 1, 0, 1, 0, 0, 4'd0, 0);
        for (int i = 0; i < 4; i++) begin idle(2, 0); idle(1, 1); end
        // R11: stack full blocks, then releases
        step(7'h01, 0, 0, 0, 1, 0, 4'd0, 0);
        for (int i = 0; i < 4; i++) step(7'h0, 1, 1, 0, 0, 0, 4'd0, 0);
        idle(6, 1);
        // R5: disabled source ignored while pending
        sw(4'd3, 0);
        step(7'h04, 0, 0, 0, 1, 0, 4'd0, 0);
        idle(5, 1);
        // R9: unused codes ignored, sub-flag clear by software
        sw(4'd14, 1); sw(4'd15, 0); sw(4'd11, 0); sw(4'd12, 0); sw(4'd13, 0);

        // random phase
        void'($urandom(32'd1234));
        for (int i = 0; i < 4000; i++) begin
            logic [6:0] ev;
            ev = '0;
            for (int b = 0; b < 7; b++) ev[b] = ($urandom % 16) == 0;
            step(ev, ($urandom % 3) == 0, ($urandom % 6) == 0,
                 ($urandom % 3) == 0, ($urandom % 20) == 0,
                 ($urandom % 8) == 0, 4'($urandom % 16), 1'($urandom % 4 != 0));
        end
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule